// File: doc/BRIEF.md
# Modem Control and Status with Loopback

This block holds the modem-control register of a 16550-style serial port and produces its modem-status register. A host writes the control register through a simple strobe-and-address port and reads either register back through a combinational read port. No external modem pins are connected.

Outside loopback the status lines report fixed values: carrier detect and data-set-ready are high, and clear-to-send and ring are low. When the loopback bit is set, each status line follows one control bit instead.

Every control write compares the status lines before and after the write. A change latches a sticky change flag in the low nibble of the status register. A status read returns the register and then clears those flags. The block also exports the current status byte, the loopback flag and a combined modem-change flag that interrupt logic can use.

Top module: `mdm_loop_top`

## Requirements
- R1: A write to the control address stores only `wr_data[4:0]`. A read of the control address returns the stored bits in positions 4:0 and zeros in positions 7:5. `loopback_o` equals stored bit 4. Bit 0 is DTR, bit 1 is RTS, bit 2 is OUT1, bit 3 is OUT2 and bit 4 is loopback.
- R2: When the loopback bit is set, the upper status nibble is DCD (bit 7) = OUT2, RI (bit 6) = OUT1, DSR (bit 5) = DTR and CTS (bit 4) = RTS.
- R3: When the loopback bit is clear, status bits 7:4 read 4'b1010: DCD and DSR are high, RI and CTS are low.
- R4: On a control write, a change of CTS sets status bit 0. A change of DSR sets bit 1. A change of DCD sets bit 3.
- R5: Status bit 2 (ring trailing edge) is set by a control write only when RI goes from 1 to 0. A rising RI leaves it clear.
- R6: Change flags in status bits 3:0 stay set across later control writes. Status bits 7:4 always show the status computed from the current control value.
- R7: A read of the status address returns the current status byte. After that clock edge, status bits 3:0 are zero unless R9 applies.
- R8: A write to the status address has no effect on the status byte or on the control register.
- R9: If a status read and a flag-setting control write occur in the same cycle, the read returns the old byte. The newly set flags remain set afterwards.
- R10: `modem_chg_o` is high exactly when any of status bits 3:0 is set.
- R11: After reset the control register is 0, the status byte is 8'hA0, and `loopback_o` and `modem_chg_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Host write register address |
| wr_data | input | 8 | Host write data |
| rd_en | input | 1 | Host read strobe; reading the status address clears the change flags |
| rd_addr | input | ADDR_W | Host read register address |
| rd_data | output | 8 | Read data for `rd_addr`, combinational |
| msr_o | output | 8 | Current modem-status byte |
| loopback_o | output | 1 | Loopback mode is active |
| modem_chg_o | output | 1 | At least one status change flag is pending |

## Verification
The assertions check on every cycle that control readback has zero upper bits and that status is fixed outside loopback. They also check that a loopback write mirrors the written bits into status and that flags are sticky without a read. Further checks cover clearing after a read, that status writes change nothing, that the ring flag rises only on a falling RI, and that the change flag only rises after a control write. The bench sweeps every pair of old and new 5-bit control values and compares the full delta pattern with a computed model. Only directed scenarios show the accumulation of flags across writes and the same-cycle read-and-set ordering.

// File: rtl/mdm_pkg.sv
// Package: shared types for the modem control/status block.
// Assumes: control bit order DTR, RTS, OUT1, OUT2, LOOP (bit 0 upward);
// status line order CTS, DSR, RI, DCD (bit 0 upward within a nibble).
package mdm_pkg;

    localparam int CTRL_W  = 5;
    localparam int LINES_N = 4;

    typedef struct packed {
        logic loop;
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } ctrl_t;

    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } lines_t;

    // Line index whose change flag records only a 1-to-0 transition.
    localparam int FALL_ONLY_IDX = 2;

    // Status lines seen when loopback is off.
    localparam lines_t IDLE_LINES = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b0};

endpackage

// File: rtl/mdm_ctrl_reg.sv
// Module: modem-control register.
// Holds the five writable control bits and presents both the stored value
// and the value that a write in this cycle would store.
// Assumes: the write address is compared against a single parameter.
module mdm_ctrl_reg
    import mdm_pkg::*;
#(
    parameter int                ADDR_W   = 3,
    parameter logic [ADDR_W-1:0] CTRL_ADR = ADDR_W'(4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output ctrl_t             ctrl_q,
    output ctrl_t             ctrl_nx,
    output logic              ctrl_wr
);

    // Decode a control write and mask the incoming data to its legal bits.
    always_comb begin
        ctrl_wr = wr_en && (wr_addr == CTRL_ADR);
        ctrl_nx = ctrl_wr ? ctrl_t'(wr_data[CTRL_W-1:0]) : ctrl_q;
    end

    // Store the control value; reset clears every bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_nx;
        end
    end

endmodule

// File: rtl/mdm_line_map.sv
// Module: maps a control value to the four status lines.
// In loopback each line follows one control bit. Otherwise the lines take
// the fixed idle pattern. Purely combinational.
module mdm_line_map
    import mdm_pkg::*;
(
    input  ctrl_t  ctrl,
    output lines_t lines
);

    // Select the loopback mirror or the fixed idle lines.
    always_comb begin
        if (ctrl.loop) begin
            lines.cts = ctrl.rts;
            lines.dsr = ctrl.dtr;
            lines.ri  = ctrl.out1;
            lines.dcd = ctrl.out2;
        end else begin
            lines = IDLE_LINES;
        end
    end

endmodule

// File: rtl/mdm_delta_track.sv
// Module: sticky change flags, one lane per status line.
// A lane sets on an update whose old/new lines differ. The lane named by
// FALL_ONLY_IDX sets only on a 1-to-0 step. A clear request drops the flags
// held so far, but a flag set in the same cycle survives.
module mdm_delta_track
    import mdm_pkg::*;
#(
    parameter int NLANES = LINES_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [NLANES-1:0] old_lines,
    input  logic [NLANES-1:0] new_lines,
    input  logic              clr,
    output logic [NLANES-1:0] flags_q
);

    logic [NLANES-1:0] hit;

    // Per-lane edge detection; the lane kind is chosen by index.
    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        if (g == FALL_ONLY_IDX) begin : g_fall
            // Falling edge only.
            always_comb hit[g] = upd && old_lines[g] && !new_lines[g];
        end else begin : g_any
            // Any change.
            always_comb hit[g] = upd && (old_lines[g] ^ new_lines[g]);
        end
    end

    // Hold flags; a clear wipes prior flags while new hits still land.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (clr ? '0 : flags_q) | hit;
        end
    end

endmodule

// File: rtl/mdm_loop_top.sv
// Module: modem control/status block with loopback.
// Status bits 7:4 are derived from the stored control value; bits 3:0 are
// sticky change flags cleared by a status read. Reads are combinational.
// Assumes: the host never depends on rd_data for addresses other than the
// control and status addresses (those read as zero).
module mdm_loop_top
    import mdm_pkg::*;
#(
    parameter int                ADDR_W   = 3,
    parameter logic [ADDR_W-1:0] CTRL_ADR = ADDR_W'(4),
    parameter logic [ADDR_W-1:0] STAT_ADR = ADDR_W'(6)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [7:0]        msr_o,
    output logic              loopback_o,
    output logic              modem_chg_o
);

    ctrl_t               ctrl_q;
    ctrl_t               ctrl_nx;
    logic                ctrl_wr;
    lines_t              lines_now;
    lines_t              lines_nx;
    logic [LINES_N-1:0]  flags;
    logic                stat_rd;

    mdm_ctrl_reg #(
        .ADDR_W   (ADDR_W),
        .CTRL_ADR (CTRL_ADR)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q),
        .ctrl_nx (ctrl_nx),
        .ctrl_wr (ctrl_wr)
    );

    mdm_line_map u_map_now (
        .ctrl  (ctrl_q),
        .lines (lines_now)
    );

    mdm_line_map u_map_nx (
        .ctrl  (ctrl_nx),
        .lines (lines_nx)
    );

    // Status read strobe used for clear-on-read.
    always_comb stat_rd = rd_en && (rd_addr == STAT_ADR);

    mdm_delta_track #(
        .NLANES (LINES_N)
    ) u_delta (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd       (ctrl_wr),
        .old_lines (lines_now),
        .new_lines (lines_nx),
        .clr       (stat_rd),
        .flags_q   (flags)
    );

    // Assemble outputs from stored state.
    always_comb begin
        msr_o       = {lines_now, flags};
        loopback_o  = ctrl_q.loop;
        modem_chg_o = |flags;
    end

    // Read data mux by address.
    always_comb begin
        if (rd_addr == CTRL_ADR) begin
            rd_data = {{(8 - CTRL_W){1'b0}}, ctrl_q};
        end else if (rd_addr == STAT_ADR) begin
            rd_data = msr_o;
        end else begin
            rd_data = 8'h00;
        end
    end

endmodule

// File: rtl/mdm_loop_chk.sv
// Module: assertion checker for mdm_loop_top, attached by bind.
// Observes only the top-level ports.
module mdm_loop_chk #(
    parameter int                ADDR_W   = 3,
    parameter logic [ADDR_W-1:0] CTRL_ADR = ADDR_W'(4),
    parameter logic [ADDR_W-1:0] STAT_ADR = ADDR_W'(6)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data,
    input logic [7:0]        msr_o,
    input logic              loopback_o,
    input logic              modem_chg_o
);

    logic ctrl_w;
    logic stat_w;
    logic stat_r;

    // Decode strobes locally from the ports.
    always_comb begin
        ctrl_w = wr_en && (wr_addr == CTRL_ADR);
        stat_w = wr_en && (wr_addr == STAT_ADR);
        stat_r = rd_en && (rd_addr == STAT_ADR);
    end

    // R1: control readback has zero upper bits.
    a_r1_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == CTRL_ADR) |-> (rd_data[7:5] == 3'b000));

    // R2: a loopback control write is mirrored into the status lines.
    a_r2_loop_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_w && wr_data[4]) |=>
        (msr_o[7:4] == {$past(wr_data[3]), $past(wr_data[2]),
                        $past(wr_data[0]), $past(wr_data[1])}));

    // R3: outside loopback the lines are fixed.
    a_r3_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !loopback_o |-> (msr_o[7:4] == 4'b1010));

    // R5: the ring flag rises only when RI fell.
    a_r5_ring_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msr_o[2]) |-> ($past(msr_o[6]) && !msr_o[6]));

    // R6: without a status read, set flags stay set.
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_r |=> ((msr_o[3:0] & $past(msr_o[3:0])) == $past(msr_o[3:0])));

    // R7: a status read with no control write leaves no flags.
    a_r7_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_r && !ctrl_w) |=> (msr_o[3:0] == 4'h0));

    // R8: a status write changes nothing.
    a_r8_stat_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_w && !stat_r) |=> (msr_o == $past(msr_o)));

    // R10: the change flag only rises after a control write.
    a_r10_chg_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(modem_chg_o) |-> $past(ctrl_w));

endmodule

bind mdm_loop_top mdm_loop_chk #(
    .ADDR_W   (ADDR_W),
    .CTRL_ADR (CTRL_ADR),
    .STAT_ADR (STAT_ADR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .msr_o       (msr_o),
    .loopback_o  (loopback_o),
    .modem_chg_o (modem_chg_o)
);

// File: tb/test_mdm_loop_top.sv
// Bench: directed scenarios plus a sweep over every old/new control pair.
module test_mdm_loop_top;

    localparam int         AW = 3;
    localparam logic [2:0] CA = 3'd4;
    localparam logic [2:0] SA = 3'd6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic [7:0]    msr_o;
    logic          loopback_o;
    logic          modem_chg_o;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    mdm_loop_top #(.ADDR_W(AW), .CTRL_ADR(CA), .STAT_ADR(SA)) i_mdm_loop_top (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .rd_en (rd_en), .rd_addr (rd_addr),
        .rd_data (rd_data), .msr_o (msr_o), .loopback_o (loopback_o),
        .modem_chg_o (modem_chg_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Status lines {DCD,RI,DSR,CTS} expected for a control value.
    function automatic logic [3:0] lines_of(input logic [4:0] c);
        return c[4] ? {c[3], c[2], c[0], c[1]} : 4'b1010;
    endfunction

    function automatic logic [3:0] flags_of(input logic [3:0] o, input logic [3:0] n);
        return {o[3] ^ n[3], o[2] & ~n[2], o[1] ^ n[1], o[0] ^ n[0]};
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11 msr", msr_o, 8'hA0);
        chk("R11 flags", {6'b0, loopback_o, modem_chg_o}, 8'h00);
        rd(CA, v); chk("R11 ctrl", v, 8'h00);

        // R4 R6: loopback on with all low, then RTS high without reading
        wr(CA, 8'h10); chk("R4 loop entry", msr_o, 8'h0A);
        wr(CA, 8'h12); chk("R6 sticky", msr_o, 8'h1B);
        chk("R10 chg high", {7'b0, modem_chg_o}, 8'h01);
        // R7: read returns then clears
        rd(SA, v); chk("R7 read value", v, 8'h1B);
        chk("R7 cleared", msr_o, 8'h10);
        chk("R10 chg low", {7'b0, modem_chg_o}, 8'h00);
        // R8: status writes ignored
        wr(SA, 8'hFF); chk("R8 msr", msr_o, 8'h10);
        rd(CA, v); chk("R8 ctrl", v, 8'h12);
        // R9: drop RTS (DCTS), then read while raising RTS in same cycle
        wr(CA, 8'h10); chk("R9 setup", msr_o, 8'h01);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = SA; wr_en = 1'b1; wr_addr = CA; wr_data = 8'h12;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        chk("R9 old value", v, 8'h01);
        chk("R9 new flag kept", msr_o, 8'h11);

        // Sweep all old/new pairs (R1-style masking with junk upper bits)
        for (int o = 0; o < 32; o++) begin
            for (int n = 0; n < 32; n++) begin
                logic [4:0] oc, nc;
                logic [3:0] eo, en;
                oc = 5'(o); nc = 5'(n);
                wr(CA, {3'(o + n), oc});
                rd(SA, v);
                wr(CA, {3'(o * 3 + 5), nc});
                eo = lines_of(oc); en = lines_of(nc);
                rd(CA, v); chk("R1 ctrl mask", v, {3'b000, nc});
                chk("R1 loopback", {7'b0, loopback_o}, {7'b0, nc[4]});
                chk(nc[4] ? "R2 R4 R5 msr" : "R3 R4 msr", msr_o, {en, flags_of(eo, en)});
                chk("R10 chg", {7'b0, modem_chg_o}, {7'b0, |flags_of(eo, en)});
                rd(SA, v); chk("R7 sweep read", v, {en, flags_of(eo, en)});
                chk("R7 sweep clear", msr_o, {en, 4'h0});
            end
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule